// File: doc/BRIEF.md
# Dual-Compare Timer Waveform Generator

This block is a 16-bit up-counter with two compare values that together shape a periodic pulse. The counter advances by one on each cycle where the count-enable strobe `tick` is high and `run` is set. When the count equals compare value B on such a step, the counter goes back to zero instead of advancing. One step after the count equals compare value A, the waveform turns active. It stays active until the B wrap. Each of these two events also raises a one-cycle interrupt strobe.

The pin idles at a level set by two control bits. `initLevel` XOR `invert` gives the idle level, and the active level is its complement. When `outEn` is low the pin is held at the idle level and the active phase is cleared, so a fresh enable always starts from the idle level. `preset` clears the counter at any time and takes priority over counting. The block is meant to sit behind a register interface and a prescaler, both of which belong to the surrounding logic.

Top module: `dual_cmp_timer`

## Requirements
- R1: On a clock edge where `run`=1, `tick`=1, `preset`=0 and `count`≠`cmpB`, `count` increases by one. With `run`=0 or `tick`=0 it holds its value.
- R2: On a stepping edge (`run`=1, `tick`=1, `preset`=0) where `count`=`cmpB`, `count` becomes 0 and `irqB` is high for exactly the following cycle.
- R3: On a stepping edge where `count`=`cmpA` and `count`≠`cmpB`, `irqA` is high for the following cycle and the phase turns active (provided `outEn`=1). With A=3 and B=5 the count runs 0,1,2,3,4,5,0, and the pin is active while the count is 4 and 5.
- R4: The B wrap returns the phase to inactive, so the pin is at the idle level in the cycle where `count` is 0 after the wrap.
- R5: `waveOut` equals the idle level (`initLevel` XOR `invert`) while the phase is inactive, and the complement of that level while the phase is active. This holds for all four combinations of the two bits.
- R6: While `outEn`=0, `waveOut` equals the idle level and the phase is held inactive. After `outEn` returns to 1, the pin stays idle until the next A step.
- R7: `preset`=1 clears `count` to 0 and the phase to inactive on the next edge, regardless of `run` and `tick`. No interrupt strobe follows that edge.
- R8: When `cmpA`≥`cmpB` and counting starts from 0, `irqA` never fires and the pin never leaves the idle level. Only `irqB` events occur. When A equals B, the wrap takes priority.
- R9: `irqA` and `irqB` are never high together, and each is high only in the cycle right after a stepping edge.
- R10: After reset, `count`=0, `irqA`=`irqB`=0 and `waveOut` is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable strobe from the prescaler |
| run | input | 1 | Allows counting |
| preset | input | 1 | Clears counter and phase |
| outEn | input | 1 | Enables the waveform on the pin |
| initLevel | input | 1 | Base idle level |
| invert | input | 1 | Inverts idle and active levels |
| cmpA | input | 16 | Compare value A (activation point) |
| cmpB | input | 16 | Compare value B (wrap point) |
| waveOut | output | 1 | Waveform pin |
| irqA | output | 1 | Compare-A interrupt strobe |
| irqB | output | 1 | Compare-B interrupt strobe |
| count | output | 16 | Current counter value |

## Verification
The bench targets the off-by-one at the A point. A design that switched the pin on the A match itself would turn active one cycle early. Both A=B and A>B are exercised: a design that gave A priority would raise `irqA` and flash the pin on every wrap. The bench also toggles `outEn` and `preset` in the middle of the active phase. A design that kept the phase across a disable would restart active, and one that raised `irqB` on a preset would emit a spurious interrupt. Gaps in `tick` catch strobes or counts that move without a count-enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic clear;  // preset: counter to zero
    logic wrap;   // compare-B step: counter to zero
    logic inc;    // ordinary step: counter plus one
    logic hitA;   // compare-A step: phase goes active
  } ctlStrobes_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  strb,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        count <= '0;
    else if (strb.clear || strb.wrap) count <= '0;
    else if (strb.inc)                count <= count + ONE;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         run,
  input  logic         preset,
  input  logic         outEn,
  input  logic         initLevel,
  input  logic         invert,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] cmpB,
  input  logic [W-1:0] count,
  output ctlStrobes_t  strb,
  output logic         waveOut,
  output logic         irqA,
  output logic         irqB
);
  logic step;
  logic matchA;
  logic matchB;
  logic active;
  logic idleLevel;

  assign step   = run && tick && !preset;
  assign matchA = (count == cmpA);
  assign matchB = (count == cmpB);

  always_comb begin
    strb.clear = preset;
    strb.wrap  = step && matchB;
    strb.inc   = step && !matchB;
    strb.hitA  = step && !matchB && matchA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      irqA   <= 1'b0;
      irqB   <= 1'b0;
    end else begin
      irqA <= strb.hitA;
      irqB <= strb.wrap;
      if (strb.clear || strb.wrap || !outEn) active <= 1'b0;
      else if (strb.hitA)                    active <= 1'b1;
    end
  end

  assign idleLevel = initLevel ^ invert;
  assign waveOut   = outEn ? (idleLevel ^ active) : idleLevel;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         run,
  input  logic         preset,
  input  logic         outEn,
  input  logic         initLevel,
  input  logic         invert,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] cmpB,
  output logic         waveOut,
  output logic         irqA,
  output logic         irqB,
  output logic [W-1:0] count
);
  ctlStrobes_t strb;

  tmr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .run(run), .preset(preset),
    .outEn(outEn), .initLevel(initLevel), .invert(invert),
    .cmpA(cmpA), .cmpB(cmpB), .count(count), .strb(strb),
    .waveOut(waveOut), .irqA(irqA), .irqB(irqB)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count)
  );
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         tick,
  input logic         run,
  input logic         preset,
  input logic         outEn,
  input logic         initLevel,
  input logic         invert,
  input logic [W-1:0] cmpA,
  input logic [W-1:0] cmpB,
  input logic         waveOut,
  input logic         irqA,
  input logic         irqB,
  input logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && !preset && count != cmpB) |=> count == $past(count) + ONE); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(run && tick) && !preset) |=> $stable(count)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && !preset && count == cmpB) |=> (count == '0 && irqB)); // R2
  AST_A_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && !preset && count == cmpA && count != cmpB) |=> irqA); // R3
  AST_WRAP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqB && outEn) |-> waveOut == (initLevel ^ invert)); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> waveOut == (initLevel ^ invert)); // R6
  AST_PRESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    preset |=> (count == '0 && !irqA && !irqB)); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(irqA && irqB)); // R9
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (irqA || irqB) |-> $past(run && tick && !preset)); // R9
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .run(run), .preset(preset),
  .outEn(outEn), .initLevel(initLevel), .invert(invert),
  .cmpA(cmpA), .cmpB(cmpB), .waveOut(waveOut), .irqA(irqA),
  .irqB(irqB), .count(count)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, run = 1'b0, preset = 1'b0, outEn = 1'b0;
  logic        initLevel = 1'b0, invert = 1'b0;
  logic [15:0] cmpA = 16'd3, cmpB = 16'd5;
  logic        waveOut, irqA, irqB;
  logic [15:0] count;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [15:0] mCount = '0;
  logic        mActive = 1'b0, mIrqA = 1'b0, mIrqB = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .run(run), .preset(preset),
    .outEn(outEn), .initLevel(initLevel), .invert(invert),
    .cmpA(cmpA), .cmpB(cmpB), .waveOut(waveOut), .irqA(irqA),
    .irqB(irqB), .count(count)
  );

  function automatic logic expWave(logic act);
    logic idle;
    idle = initLevel ^ invert;
    return outEn ? (idle ^ act) : idle;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare all outputs with the reference (called at negedge, before new inputs)
  task automatic compareAll();
    check("R1", "count", count, mCount);
    check("R3", "irqA", irqA, mIrqA);
    check("R2", "irqB", irqB, mIrqB);
    check("R5", "waveOut", waveOut, expWave(mActive));
  endtask

  // one clock: inputs already driven; update reference for the coming edge
  task automatic cycle();
    logic step, mb, ma;
    logic [15:0] nc;
    logic na, nia, nib;
    step = run && tick && !preset;
    mb = (mCount == cmpB);
    ma = (mCount == cmpA);
    nc = mCount; na = mActive;
    nia = step && !mb && ma;
    nib = step && mb;
    if (preset || nib) nc = '0;
    else if (step)     nc = mCount + 16'd1;
    if (preset || nib || !outEn) na = 1'b0;
    else if (nia)                na = 1'b1;
    @(posedge clk);
    mCount = nc; mActive = na; mIrqA = nia; mIrqB = nib;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "count after reset", count, 0);
    check("R10", "irqA after reset", irqA, 0);
    check("R10", "irqB after reset", irqB, 0);
    check("R10", "waveOut after reset", waveOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed A=3, B=5, all four level combinations
    for (int combo = 0; combo < 4; combo++) begin
      initLevel = combo[0]; invert = combo[1];
      preset = 1'b1; run = 1'b0; tick = 1'b0; outEn = 1'b1;
      cycle();
      check("R7", "count after preset", count, 0);
      preset = 1'b0; run = 1'b1; tick = 1'b1;
      for (int k = 0; k < 14; k++) begin
        logic idle;
        idle = combo[0] ^ combo[1];
        cycle();
        // count 4,5 active; others idle (R3, R4, R5)
        if (count == 16'd4 || count == 16'd5)
          check("R3", "active level", waveOut, !idle);
        else
          check("R4", "idle level", waveOut, idle);
        if (count == 16'd0) check("R2", "irqB at wrap", irqB, 1);
      end
    end

    // R6: disable in the active phase, re-enable
    initLevel = 1'b0; invert = 1'b0;
    while (count != 16'd4) cycle();
    outEn = 1'b0;
    cycle();
    check("R6", "disabled pin", waveOut, 0);
    outEn = 1'b1;
    cycle();
    check("R6", "re-enabled pin stays idle", waveOut, 0);

    // R7: preset mid-count while running, no strobe
    while (count != 16'd3) cycle();
    preset = 1'b1;
    cycle();
    check("R7", "preset count", count, 0);
    check("R7", "preset no irqA", irqA, 0);
    preset = 1'b0;

    // R9: tick gaps
    tick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cycle();
      check("R9", "no irq without tick", irqA | irqB, 0);
    end
    tick = 1'b1;

    // R8: A == B and A > B
    for (int v = 0; v < 2; v++) begin
      cmpA = (v == 0) ? 16'd4 : 16'd9; cmpB = 16'd4;
      preset = 1'b1; cycle(); preset = 1'b0;
      for (int k = 0; k < 20; k++) begin
        cycle();
        check("R8", "no irqA when A>=B", irqA, 0);
        check("R8", "pin idle when A>=B", waveOut, 0);
      end
    end

    // random phase
    for (int k = 0; k < 4000; k++) begin
      tick   = ($urandom % 4) != 0;
      run    = ($urandom % 8) != 0;
      preset = ($urandom % 40) == 0;
      if ($urandom % 50 == 0) outEn = ~outEn;
      if ($urandom % 200 == 0) begin initLevel = $urandom; invert = $urandom; end
      if ($urandom % 150 == 0) begin
        cmpA = 16'($urandom % 8); cmpB = 16'($urandom % 8);
        preset = 1'b1;
      end
      cycle();
      check("R9", "irq exclusive", irqA & irqB, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule